// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a parameterised cache with two ways per set, placed between a processor-side request port and a next-level memory port. The processor port has a read strobe, a write strobe, an address, write data, read data, a ready signal and a hit flag. The next-level port moves whole blocks, using a request line that stays high until an acknowledge pulse arrives. A strobe mask marks which words of a write are meant to land in memory.

Each request address is split into a block offset, a set index and a tag. The two tags of the selected set are compared in parallel. On a hit the access finishes in the cycle it is presented. On a miss the line is fetched from memory and placed in a way of the set:
- an empty way is used first, the lower-numbered one when both are empty;
- when both ways are full, the way used least recently is replaced, tracked with one bit per set.

A mode input selects how writes are handled:
- In write-back mode, a write changes only the cache and marks the line dirty. A dirty line is copied back to memory before its way is refilled.
- In write-through mode, every write is also sent to memory.

Write misses allocate the line first and then apply the write.

Top module: `cache2way`

## Requirements
- R1: The address is split from the least significant end: the low OFF_W bits are the word offset, the next IDX_W bits are the set index, and the remaining bits are the tag. Word i of a block sits at bits [i*DATA_W +: DATA_W] of memRdata and memWdata. memAddr is the block address, {tag, index}.
- R2: A read hit completes in the cycle the request is presented, with cpuReady=1 and cpuHit=1. cpuRdata is the word selected by the offset.
- R3: A miss places the fetched block in way 0 if it is empty, otherwise in way 1 if that is empty. Only when both are valid is a line evicted.
- R4: When both ways are valid, a miss evicts the way accessed least recently, where reads and writes both count as accesses. Consider two sets of two one-block ways, with the block sequence 0,2,0,1,4,0,2,3,5,4. That sequence gives hits only on the 3rd and 6th accesses, and leaves blocks 2,3,4,5 resident.
- R5: In write-back mode (wbMode=1), a write hit completes in one cycle and issues no memory write. When a dirty victim is evicted, it is first written to memory as one block write with memStrb all ones and its own block address, and only then is the fill read issued. A clean victim causes no memory write.
- R6: In write-through mode (wbMode=0), a write hit issues one memory write to the request's block address. memStrb is one-hot at the offset, and memWdata carries the new word in that slot. cpuHit=1 is reported when the access completes.
- R7: A write miss fetches the block and then applies the write; the access completes with cpuHit=0. In write-through mode the fill is followed by a memory write of the word.
- R8: After reset no line is valid and every replacement bit selects way 0. With no request pending, cpuReady=1 and memReq=0.
- R9: While a memory transfer is outstanding, cpuReady=0. memReq, memWe and memAddr stay steady until memAck. Each block transfer uses exactly one handshake.
- R10: A read miss completes with cpuHit=0 and the word from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wbMode | input | 1 | 1 = write-back, 0 = write-through |
| cpuAddr | input | ADDR_W | Word address of the request |
| cpuRd | input | 1 | Read request, held until cpuReady |
| cpuWr | input | 1 | Write request, held until cpuReady |
| cpuWdata | input | DATA_W | Write word |
| cpuRdata | output | DATA_W | Read word, valid when cpuReady |
| cpuReady | output | 1 | Request completes at this clock edge |
| cpuHit | output | 1 | Completing request hit in the cache |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | ADDR_W-OFF_W | Block address |
| memStrb | output | 2**OFF_W | Word enables of a write |
| memWdata | output | DATA_W*2**OFF_W | Block written to memory |
| memRdata | input | DATA_W*2**OFF_W | Block read from memory, valid with memAck |
| memAck | input | 1 | One-cycle acknowledge of the transfer |

## Verification
A hit is due combinationally, so the bench samples ready, hit and data one time unit after the falling edge on which it drove the request. It expects completion at that first sample. A clean read miss is due after the memory model's latency plus the cycle that returns to the respond state, and the bench checks that exact count of sample points. Memory-side effects are checked once the access has completed: write counts, block address, strobe, the order of the write-back relative to the fill, and the contents of the bench memory.

// File: rtl/cache2way_pkg.sv
package cache2way_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU,
    ST_RESP
  } ctlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fill;       // write fetched block into the victim way
    logic commit;     // access completes: update LRU, apply write
    logic selVictim;  // memory port addresses the victim line
  } ctlStrobes_t;

endpackage

// File: rtl/cache2way_dp.sv
module cache2way_dp
  import cache2way_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wbMode,
  input  logic [ADDR_W-1:0]                 cpuAddr,
  input  logic                              cpuWr,
  input  logic [DATA_W-1:0]                 cpuWdata,
  input  ctlStrobes_t                       stb,
  input  logic [DATA_W*(2**OFF_W)-1:0]      memRdata,
  output logic                              hit,
  output logic                              victimDirty,
  output logic [DATA_W-1:0]                 cpuRdata,
  output logic [ADDR_W-OFF_W-1:0]           memAddr,
  output logic [(2**OFF_W)-1:0]             memStrb,
  output logic [DATA_W*(2**OFF_W)-1:0]      memWdata
);
  localparam int WORDS = 2 ** OFF_W;
  localparam int SETS  = 2 ** IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int BLK_W = DATA_W * WORDS;

  logic [SETS-1:0][1:0] validQ;
  logic [SETS-1:0][1:0] dirtyQ;
  logic [SETS-1:0]      lruQ;
  logic [TAG_W-1:0]     tagQ  [SETS][2];
  logic [BLK_W-1:0]     dataQ [SETS][2];

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;
  logic [1:0]       wayHit;
  logic             hitWay;
  logic             victimWay;
  logic [BLK_W-1:0] hitLine;
  logic [BLK_W-1:0] mergedLine;

  assign reqOff = cpuAddr[OFF_W-1:0];
  assign reqIdx = cpuAddr[OFF_W +: IDX_W];
  assign reqTag = cpuAddr[ADDR_W-1 -: TAG_W];

  // Parallel tag compare, one comparator per way
  for (genvar w = 0; w < 2; w++) begin : gCmp
    assign wayHit[w] = validQ[reqIdx][w] && (tagQ[reqIdx][w] == reqTag);
  end

  assign hit    = |wayHit;
  assign hitWay = wayHit[1];

  // Empty way first (lowest number), else least recently used
  always_comb begin
    if (!validQ[reqIdx][0])      victimWay = 1'b0;
    else if (!validQ[reqIdx][1]) victimWay = 1'b1;
    else                         victimWay = lruQ[reqIdx];
  end

  assign victimDirty = validQ[reqIdx][victimWay] && dirtyQ[reqIdx][victimWay];
  assign hitLine     = dataQ[reqIdx][hitWay];
  assign cpuRdata    = hitLine[reqOff*DATA_W +: DATA_W];

  for (genvar i = 0; i < WORDS; i++) begin : gMerge
    assign mergedLine[i*DATA_W +: DATA_W] =
      (reqOff == OFF_W'(i)) ? cpuWdata : hitLine[i*DATA_W +: DATA_W];
  end

  assign memAddr  = stb.selVictim ? {tagQ[reqIdx][victimWay], reqIdx} : {reqTag, reqIdx};
  assign memWdata = stb.selVictim ? dataQ[reqIdx][victimWay] : mergedLine;
  assign memStrb  = stb.selVictim ? {WORDS{1'b1}} : (WORDS'(1) << reqOff);

  // Status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= '0;
      dirtyQ <= '0;
      lruQ   <= '0;
    end else begin
      if (stb.fill) begin
        validQ[reqIdx][victimWay] <= 1'b1;
        dirtyQ[reqIdx][victimWay] <= 1'b0;
      end
      if (stb.commit) begin
        lruQ[reqIdx] <= ~hitWay;
        if (cpuWr && wbMode) dirtyQ[reqIdx][hitWay] <= 1'b1;
      end
    end
  end

  // Tag and data storage
  always_ff @(posedge clk) begin
    if (stb.fill) begin
      tagQ[reqIdx][victimWay]  <= reqTag;
      dataQ[reqIdx][victimWay] <= memRdata;
    end else if (stb.commit && cpuWr) begin
      dataQ[reqIdx][hitWay] <= mergedLine;
    end
  end

endmodule

// File: rtl/cache2way_ctrl.sv
module cache2way_ctrl
  import cache2way_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wbMode,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic        hit,
  input  logic        victimDirty,
  input  logic        memAck,
  output ctlStrobes_t stb,
  output logic        cpuReady,
  output logic        cpuHit,
  output logic        memReq,
  output logic        memWe
);
  ctlState_t stateQ, stateD;
  logic      missQ, missD;
  logic      access;
  logic      wtWrite;

  assign access  = cpuRd | cpuWr;
  assign wtWrite = cpuWr & ~wbMode;

  always_comb begin
    stateD   = stateQ;
    missD    = missQ;
    stb      = '0;
    cpuReady = 1'b0;
    cpuHit   = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (!access) begin
          cpuReady = 1'b1;
        end else if (hit) begin
          if (wtWrite) begin
            stateD = ST_WTHRU;
            missD  = 1'b0;
          end else begin
            cpuReady   = 1'b1;
            cpuHit     = 1'b1;
            stb.commit = 1'b1;
          end
        end else begin
          missD  = 1'b1;
          stateD = victimDirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        memReq        = 1'b1;
        memWe         = 1'b1;
        stb.selVictim = 1'b1;
        if (memAck) stateD = ST_FILL;
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          stb.fill = 1'b1;
          stateD   = wtWrite ? ST_WTHRU : ST_RESP;
        end
      end
      ST_WTHRU: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) stateD = ST_RESP;
      end
      ST_RESP: begin
        cpuReady   = 1'b1;
        cpuHit     = ~missQ;
        stb.commit = 1'b1;
        stateD     = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      missQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      missQ  <= missD;
    end
  end

endmodule

// File: rtl/cache2way.sv
module cache2way
  import cache2way_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 1,
  parameter int OFF_W  = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wbMode,
  input  logic [ADDR_W-1:0]            cpuAddr,
  input  logic                         cpuRd,
  input  logic                         cpuWr,
  input  logic [DATA_W-1:0]            cpuWdata,
  output logic [DATA_W-1:0]            cpuRdata,
  output logic                         cpuReady,
  output logic                         cpuHit,
  output logic                         memReq,
  output logic                         memWe,
  output logic [ADDR_W-OFF_W-1:0]      memAddr,
  output logic [(2**OFF_W)-1:0]        memStrb,
  output logic [DATA_W*(2**OFF_W)-1:0] memWdata,
  input  logic [DATA_W*(2**OFF_W)-1:0] memRdata,
  input  logic                         memAck
);
  localparam int WORDS   = 2 ** OFF_W;
  localparam int BADDR_W = ADDR_W - OFF_W;

  ctlStrobes_t stb;
  logic        hit;
  logic        victimDirty;

  cache2way_ctrl uCtrl (
    .clk, .rst, .wbMode, .cpuRd, .cpuWr,
    .hit, .victimDirty, .memAck,
    .stb, .cpuReady, .cpuHit, .memReq, .memWe
  );

  cache2way_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
  ) uDp (
    .clk, .rst, .wbMode, .cpuAddr, .cpuWr, .cpuWdata, .stb, .memRdata,
    .hit, .victimDirty, .cpuRdata, .memAddr, .memStrb, .memWdata
  );

endmodule

// File: rtl/cache2way_chk.sv
module cache2way_chk #(
  parameter int WORDS   = 2,
  parameter int BADDR_W = 7
) (
  input logic               clk,
  input logic               rst,
  input logic               cpuRd,
  input logic               cpuWr,
  input logic               cpuReady,
  input logic               cpuHit,
  input logic               memReq,
  input logic               memWe,
  input logic               memAck,
  input logic [BADDR_W-1:0] memAddr,
  input logic [WORDS-1:0]   memStrb
);

  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));

  // R9
  ready_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);

  // R9
  we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memReq);

  // R2
  hit_with_access_chk: assert property (@(posedge clk) disable iff (rst)
    cpuHit |-> (cpuReady && (cpuRd || cpuWr)));

  // R6
  write_strobe_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && memWe) |-> (($countones(memStrb) == 1) || (&memStrb)));

endmodule

bind cache2way cache2way_chk #(.WORDS(WORDS), .BADDR_W(BADDR_W)) uChk (
  .clk(clk), .rst(rst), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuReady(cpuReady),
  .cpuHit(cpuHit), .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memStrb(memStrb)
);

// File: tb/tb_cache2way.sv
module tb_cache2way;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 1;
  localparam int OFF_W  = 1;
  localparam int WORDS  = 2 ** OFF_W;
  localparam int BLK_W  = DATA_W * WORDS;
  localparam int NBLK   = 2 ** (ADDR_W - OFF_W);
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbMode = 1'b1;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic cpuReady, cpuHit, memReq, memWe;
  logic [ADDR_W-OFF_W-1:0] memAddr;
  logic [WORDS-1:0] memStrb;
  logic [BLK_W-1:0] memWdata;
  logic [BLK_W-1:0] memRdata = '0;
  logic memAck = 1'b0;

  int checks = 0, errors = 0;
  int rdCnt = 0, wrCnt = 0, opSeq = 0, lastRdSeq = 0, lastWrSeq = 0;
  int memCnt = 0;
  int lastWrAddr = 0;
  logic [WORDS-1:0] lastWrStrb = '0;
  logic [BLK_W-1:0] memArr [NBLK];

  always #(CLK_P/2) clk = ~clk;

  cache2way #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
    .clk, .rst, .wbMode, .cpuAddr, .cpuRd, .cpuWr, .cpuWdata, .cpuRdata,
    .cpuReady, .cpuHit, .memReq, .memWe, .memAddr, .memStrb, .memWdata,
    .memRdata, .memAck
  );

  function automatic logic [DATA_W-1:0] expWord(int b, int w);
    return 32'h1000_0000 + DATA_W'(b * 16 + w);
  endfunction

  task automatic memInit();
    for (int b = 0; b < NBLK; b++)
      for (int w = 0; w < WORDS; w++)
        memArr[b][w*DATA_W +: DATA_W] = expWord(b, w);
  endtask

  // Next-level memory: ack LAT falling edges after request
  always @(negedge clk) begin
    if (rst) begin
      memAck = 1'b0;
      memCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (memCnt == LAT - 1) begin
        memCnt = 0;
        opSeq++;
        if (memWe) begin
          wrCnt++;
          lastWrSeq  = opSeq;
          lastWrAddr = int'(memAddr);
          lastWrStrb = memStrb;
          for (int w = 0; w < WORDS; w++)
            if (memStrb[w]) memArr[memAddr][w*DATA_W +: DATA_W] = memWdata[w*DATA_W +: DATA_W];
        end else begin
          rdCnt++;
          lastRdSeq = opSeq;
          memRdata  = memArr[memAddr];
        end
        memAck = 1'b1;
      end else begin
        memCnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset(input bit mode);
    @(negedge clk);
    rst = 1'b1; cpuRd = 1'b0; cpuWr = 1'b0; wbMode = mode;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    memInit();
    rdCnt = 0; wrCnt = 0;
  endtask

  // One processor access; returns hit, data and number of sample points
  task automatic access(input logic [ADDR_W-1:0] a, input bit wr, input logic [DATA_W-1:0] d,
                        output bit h, output logic [DATA_W-1:0] rd, output int cyc);
    @(negedge clk);
    cpuAddr = a; cpuWr = wr; cpuRd = !wr; cpuWdata = d;
    #1;
    cyc = 1;
    while (!cpuReady && cyc < 200) begin
      @(negedge clk); #1; cyc++;
    end
    h = cpuHit; rd = cpuRdata;
    @(posedge clk);
    @(negedge clk);
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic testReset();
    bit h; logic [DATA_W-1:0] rd; int cyc;
    doReset(1'b1);
    #1;
    chk(cpuReady == 1'b1, "R8", "idle ready", cpuReady, 1);
    chk(memReq == 1'b0, "R8", "idle memReq", memReq, 0);
    access(8'd0, 1'b0, '0, h, rd, cyc);
    chk(h == 1'b0, "R8", "first access misses", h, 0);
    chk(rd == expWord(0, 0), "R10", "miss data", rd, expWord(0, 0));
    chk(cyc == LAT + 2, "R9", "clean miss latency", cyc, LAT + 2);
    chk(rdCnt == 1, "R9", "one fill handshake", rdCnt, 1);
    access(8'd1, 1'b0, '0, h, rd, cyc);
    chk(h && cyc == 1, "R2", "hit in one cycle", {h, cyc[7:0]}, {1'b1, 8'd1});
    chk(rd == expWord(0, 1), "R1", "offset selects word 1", rd, expWord(0, 1));
  endtask

  // Block sequence 0,2,0,1,4,0,2,3,5,4 with addr = blk*2 + offset
  task automatic testLruSeq();
    int seq [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    bit expHit [10] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0};
    int fin [6] = '{2, 3, 5, 4, 0, 1};
    bit finHit [6] = '{1, 1, 1, 1, 0, 0};
    bit h; logic [DATA_W-1:0] rd; int cyc; int hits;
    doReset(1'b1);
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      access(ADDR_W'(seq[i] * 2 + (i & 1)), 1'b0, '0, h, rd, cyc);
      if (h) hits++;
      chk(h == expHit[i], "R4", $sformatf("hit flag access %0d", i), h, expHit[i]);
      chk(rd == expWord(seq[i], i & 1), "R1", $sformatf("data access %0d", i), rd, expWord(seq[i], i & 1));
    end
    chk(hits == 2, "R4", "hit total", hits, 2);
    chk(rdCnt == 8 && wrCnt == 0, "R3", "8 fills, no writes", {rdCnt[7:0], wrCnt[7:0]}, 16'h0800);
    for (int i = 0; i < 6; i++) begin
      access(ADDR_W'(fin[i] * 2), 1'b0, '0, h, rd, cyc);
      chk(h == finHit[i], "R4", $sformatf("residency block %0d", fin[i]), h, finHit[i]);
    end
  endtask

  task automatic testWriteBack();
    bit h; logic [DATA_W-1:0] rd; int cyc;
    doReset(1'b1);
    access(8'd1, 1'b1, 32'hDEAD_0001, h, rd, cyc);
    chk(h == 1'b0 && rdCnt == 1, "R7", "write miss allocates", {h, rdCnt[7:0]}, {1'b0, 8'd1});
    access(8'd1, 1'b0, '0, h, rd, cyc);
    chk(h && rd == 32'hDEAD_0001, "R7", "written word read back", rd, 32'hDEAD_0001);
    chk(wrCnt == 0 && memArr[0][DATA_W +: DATA_W] == expWord(0, 1), "R5", "memory untouched",
        memArr[0][DATA_W +: DATA_W], expWord(0, 1));
    access(8'd4, 1'b0, '0, h, rd, cyc);   // block 2 fills way 1
    chk(h == 1'b0 && wrCnt == 0, "R3", "empty way filled, no eviction", wrCnt, 0);
    access(8'd8, 1'b0, '0, h, rd, cyc);   // block 4 evicts dirty block 0
    chk(wrCnt == 1 && lastWrAddr == 0, "R5", "dirty victim written back", lastWrAddr, 0);
    chk(lastWrStrb == 2'b11, "R5", "write-back strobe full", lastWrStrb, 2'b11);
    chk(lastWrSeq < lastRdSeq, "R5", "write-back before fill", lastWrSeq, lastRdSeq - 1);
    chk(memArr[0][DATA_W +: DATA_W] == 32'hDEAD_0001 && memArr[0][DATA_W-1:0] == expWord(0, 0),
        "R5", "written-back block", memArr[0][DATA_W +: DATA_W], 32'hDEAD_0001);
    chk(rd == expWord(4, 0), "R10", "data after write-back", rd, expWord(4, 0));
    access(8'd12, 1'b0, '0, h, rd, cyc);  // block 6 evicts clean block 2
    chk(wrCnt == 1, "R5", "clean victim not written", wrCnt, 1);
    access(8'd12, 1'b1, 32'h1234_5678, h, rd, cyc);
    chk(h && cyc == 1 && wrCnt == 1, "R5", "write hit cache only", {h, cyc[7:0], wrCnt[7:0]}, {1'b1, 8'd1, 8'd1});
  endtask

  task automatic testWriteThrough();
    bit h; logic [DATA_W-1:0] rd; int cyc;
    doReset(1'b0);
    access(8'd0, 1'b0, '0, h, rd, cyc);
    access(8'd0, 1'b1, 32'hBEEF_0000, h, rd, cyc);
    chk(h == 1'b1 && cyc > 1, "R6", "write hit waits for memory", {h, cyc[7:0]}, {1'b1, 8'(LAT + 2)});
    chk(wrCnt == 1 && lastWrAddr == 0 && lastWrStrb == 2'b01, "R6", "one-hot word write",
        {wrCnt[7:0], lastWrStrb}, {8'd1, 2'b01});
    chk(memArr[0][DATA_W-1:0] == 32'hBEEF_0000 && memArr[0][DATA_W +: DATA_W] == expWord(0, 1),
        "R6", "memory word updated", memArr[0][DATA_W-1:0], 32'hBEEF_0000);
    access(8'd3, 1'b1, 32'hCAFE_0003, h, rd, cyc);
    chk(h == 1'b0 && rdCnt == 2 && wrCnt == 2, "R7", "write miss fill then write",
        {rdCnt[7:0], wrCnt[7:0]}, {8'd2, 8'd2});
    chk(lastWrAddr == 1 && lastWrStrb == 2'b10, "R7", "write miss strobe", lastWrStrb, 2'b10);
    chk(memArr[1][DATA_W +: DATA_W] == 32'hCAFE_0003, "R7", "memory after write miss",
        memArr[1][DATA_W +: DATA_W], 32'hCAFE_0003);
    access(8'd3, 1'b0, '0, h, rd, cyc);
    chk(h && rd == 32'hCAFE_0003, "R2", "read hit after write", rd, 32'hCAFE_0003);
    access(8'd4, 1'b0, '0, h, rd, cyc);
    access(8'd8, 1'b0, '0, h, rd, cyc);   // evicts block 0, clean in this mode
    chk(wrCnt == 2, "R6", "no write-back in write-through", wrCnt, 2);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    memInit();
    testReset();
    testLruSeq();
    testWriteBack();
    testWriteThrough();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule